// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside an SDRAM command bus and interprets each clock's control strobes (chip select, row strobe, column strobe, write enable) together with the address bus. It turns them into a compact command code, works out which of four banks the command targets, and keeps a running picture of the device's state. That picture covers which banks are open, which row each open bank holds, and what the mode register was last programmed to. It also raises a flag when a command would be illegal in the current state.

Commands that fail the legality rules are reported and do not change the tracked state. Read and write commands that carry an automatic precharge keep their bank open until the programmed burst has finished, then close it without any further command. The tracked state is meant for a controller or monitor that needs to know bank status without modelling the device itself.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After a synchronous active-low reset, every bank is closed, `mode_valid` is 0, `illegal` is 0 and `cmd_code` is 0 (no operation).
- R2: The pins `{cs_n,ras_n,cas_n,we_n}` are decoded as follows: 0011 is activate (code 1), 0101 is read, 0100 is write, 0010 is precharge, 0001 is refresh (code 8) and 0000 is mode set (code 9). A high `cs_n` or any other pattern gives no operation (code 0). Read is code 2, or 3 with A10 high. Write is code 4, or 5 with A10 high. Precharge is code 6 for one bank, or 7 for all banks with A10 high. `cmd_code`, `cmd_bank` and `illegal` show the command sampled at a clock edge from just after that edge.
- R3: The target bank is `{A13,A12}`. A legal activate opens that bank and stores A0..A11 in `bank_row` bits [12b+11:12b] for bank b.
- R4: A single-bank precharge closes only the selected bank. An all-bank precharge closes all four banks. Neither is ever illegal.
- R5: A mode set copies A0..A13 into `mode_word` and sets `mode_valid`. `burst_len` is A2..A0, where 000=1, 001=2, 010=4, 011=8 and any code with A2 high means full page. `burst_interleave` is A3 and `cas_latency` is A6..A4.
- R6: Any activate, read or write issued before the first mode set is flagged illegal and opens no bank.
- R7: A read or write to a closed bank, or an activate to an open bank, is flagged illegal. The bank state and the stored row stay unchanged.
- R8: A legal read or write with auto-precharge sampled at edge k keeps its bank open through edge k+BL-1 and closes it at edge k+BL. While the close is pending, a read or write to that bank is flagged illegal.
- R9: A read or write with auto-precharge while the burst length is full page is flagged illegal, and the bank stays open.
- R10: Refresh is legal only when all banks are closed. Otherwise it is flagged illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 14 | Address bus; A13..A12 select the bank |
| cmd_code | output | 4 | Code of the last sampled command |
| cmd_bank | output | 2 | Bank field of the last sampled command |
| illegal | output | 1 | Last sampled command broke a legality rule |
| bank_open | output | 4 | One bit per bank, high while the bank is open |
| bank_row | output | 48 | Stored row for each bank, 12 bits per bank |
| mode_valid | output | 1 | A mode set has been accepted since reset |
| mode_word | output | 14 | Last programmed mode register contents |
| burst_len | output | 3 | Burst length field |
| burst_interleave | output | 1 | Burst order field |
| cas_latency | output | 3 | Read latency field |

## Verification
A bank that is wrongly believed open or closed shows up on `bank_open` at the edge after the faulty command. It also shows up on `illegal` as soon as the next read, write, activate or refresh reaches that bank. A broken auto-precharge countdown moves the falling edge of the bank's `bank_open` bit away from edge k+BL, so the bench samples that bit on every cycle of the burst. Errors in the mode-register latch appear immediately on the field outputs. They also change whether a later auto-precharge command is accepted.

// File: rtl/sdram_trk_pkg.sv
// Package: shared command type for the SDRAM command tracker.
// Assumes: codes are fixed, since the bench and downstream logic rely on them.
package sdram_trk_pkg;
    typedef enum logic [3:0] {
        C_NOP  = 4'd0,
        C_ACT  = 4'd1,
        C_RD   = 4'd2,
        C_RDA  = 4'd3,
        C_WR   = 4'd4,
        C_WRA  = 4'd5,
        C_PRE  = 4'd6,
        C_PALL = 4'd7,
        C_REF  = 4'd8,
        C_MRS  = 4'd9
    } cmd_e;
endpackage

// File: rtl/sdram_trk_decode.sv
// Module: sdram_trk_decode
// Turns the four strobe pins plus the address bus into a command code,
// a bank index and a row value. Purely combinational.
// Assumes: the bank index sits in the top BA_W address bits.
module sdram_trk_decode
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int ROW_W  = 12,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd,
    output logic [BA_W-1:0]   bank,
    output logic [ROW_W-1:0]  row
);
    localparam int BA_LSB = ADDR_W - BA_W;

    logic [2:0] strobes;
    logic       a_flag;

    assign strobes = {ras_n, cas_n, we_n};
    assign a_flag  = addr[AP_BIT];
    assign bank    = addr[BA_LSB +: BA_W];
    assign row     = addr[ROW_W-1:0];

    // Purpose: map the strobe pattern and A10 onto a command code.
    always_comb begin
        cmd = C_NOP;
        if (!cs_n) begin
            case (strobes)
                3'b011:  cmd = C_ACT;
                3'b101:  cmd = a_flag ? C_RDA : C_RD;
                3'b100:  cmd = a_flag ? C_WRA : C_WR;
                3'b010:  cmd = a_flag ? C_PALL : C_PRE;
                3'b001:  cmd = C_REF;
                3'b000:  cmd = C_MRS;
                default: cmd = C_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_trk_mode.sv
// Module: sdram_trk_mode
// Holds the mode register and derives the burst countdown length from it.
// Assumes: a zero length marks full page, which never drives a countdown.
module sdram_trk_mode #(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] word_i,
    output logic [ADDR_W-1:0] word_o,
    output logic              valid_o,
    output logic [CNT_W-1:0]  ap_len_o,
    output logic              full_o
);
    // Purpose: capture the address bus on a mode set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else if (load_i) begin
            word_o  <= word_i;
            valid_o <= 1'b1;
        end
    end

    // Purpose: translate the length field into a cycle count.
    always_comb begin
        case (word_o[2:0])
            3'b000:  ap_len_o = CNT_W'(1);
            3'b001:  ap_len_o = CNT_W'(2);
            3'b010:  ap_len_o = CNT_W'(4);
            3'b011:  ap_len_o = CNT_W'(8);
            default: ap_len_o = '0;
        endcase
    end

    assign full_o = word_o[2];
endmodule

// File: rtl/sdram_trk_bank.sv
// Module: sdram_trk_bank
// State of one bank: open flag, stored row and pending auto-precharge countdown.
// Assumes: the caller gates act/pre/ap so that only legal requests arrive,
// and that act and pre are never raised together.
module sdram_trk_bank #(
    parameter int ROW_W = 12,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             ap_i,
    input  logic [CNT_W-1:0] ap_len_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);
    logic [CNT_W-1:0] remain;

    // Purpose: open, close, or count down to an automatic close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            pend_o <= 1'b0;
            remain <= '0;
            row_o  <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            pend_o <= 1'b0;
            row_o  <= row_i;
        end else if (pre_i) begin
            open_o <= 1'b0;
            pend_o <= 1'b0;
        end else if (ap_i) begin
            pend_o <= 1'b1;
            remain <= ap_len_i;
        end else if (pend_o) begin
            if (remain == CNT_W'(1)) begin
                open_o <= 1'b0;
                pend_o <= 1'b0;
            end else begin
                remain <= remain - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdram_cmd_tracker.sv
// Module: sdram_cmd_tracker (top)
// Decodes SDRAM commands, checks them against the tracked state, updates a
// set of per-bank trackers and the mode register, and registers the
// decoded command and its legality verdict.
// Assumes: one command per clock and a synchronous reset held for at least one edge.
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int ROW_W     = 12,
    parameter int NUM_BANKS = 4,
    parameter int AP_BIT    = 10,
    parameter int CNT_W     = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [ADDR_W-1:0]          addr,
    output logic [3:0]                 cmd_code,
    output logic [BA_W-1:0]            cmd_bank,
    output logic                       illegal,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row,
    output logic                       mode_valid,
    output logic [ADDR_W-1:0]          mode_word,
    output logic [2:0]                 burst_len,
    output logic                       burst_interleave,
    output logic [2:0]                 cas_latency
);
    cmd_e                 cmd;
    logic [BA_W-1:0]      bank_sel;
    logic [ROW_W-1:0]     row_in;
    logic [NUM_BANKS-1:0] sel_hot;
    logic [NUM_BANKS-1:0] pend_vec;
    logic [CNT_W-1:0]     ap_len;
    logic                 len_full;
    logic                 sel_open;
    logic                 sel_pend;
    logic                 bad;
    logic                 act_go;
    logic                 pre_one;
    logic                 pre_all;
    logic                 ap_go;

    sdram_trk_decode #(
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W),
        .BA_W   (BA_W),
        .AP_BIT (AP_BIT)
    ) u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .cmd   (cmd),
        .bank  (bank_sel),
        .row   (row_in)
    );

    sdram_trk_mode #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cmd == C_MRS),
        .word_i   (addr),
        .word_o   (mode_word),
        .valid_o  (mode_valid),
        .ap_len_o (ap_len),
        .full_o   (len_full)
    );

    assign burst_len        = mode_word[2:0];
    assign burst_interleave = mode_word[3];
    assign cas_latency      = mode_word[6:4];

    assign sel_hot  = NUM_BANKS'(1) << bank_sel;
    assign sel_open = bank_open[bank_sel];
    assign sel_pend = pend_vec[bank_sel];

    // Purpose: decide whether the current command breaks a legality rule.
    always_comb begin
        case (cmd)
            C_ACT:        bad = !mode_valid || sel_open;
            C_RD, C_WR:   bad = !mode_valid || !sel_open || sel_pend;
            C_RDA, C_WRA: bad = !mode_valid || !sel_open || sel_pend || len_full;
            C_REF:        bad = |bank_open;
            default:      bad = 1'b0;
        endcase
    end

    assign act_go  = (cmd == C_ACT) && !bad;
    assign pre_one = (cmd == C_PRE);
    assign pre_all = (cmd == C_PALL);
    assign ap_go   = ((cmd == C_RDA) || (cmd == C_WRA)) && !bad;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_trk_bank #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_go && sel_hot[g]),
            .pre_i    (pre_all || (pre_one && sel_hot[g])),
            .ap_i     (ap_go && sel_hot[g]),
            .ap_len_i (ap_len),
            .row_i    (row_in),
            .open_o   (bank_open[g]),
            .pend_o   (pend_vec[g]),
            .row_o    (bank_row[g*ROW_W +: ROW_W])
        );
    end

    // Purpose: register the decoded command, its bank and the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code <= 4'd0;
            cmd_bank <= '0;
            illegal  <= 1'b0;
        end else begin
            cmd_code <= cmd;
            cmd_bank <= bank_sel;
            illegal  <= bad;
        end
    end
endmodule

// File: rtl/sdram_trk_chk.sv
// Module: sdram_trk_chk
// Checker bound to the tracker: relates the registered command report to
// the bank and mode state seen at the ports.
module sdram_trk_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           cmd_code,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 illegal,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 mode_valid,
    input logic [2:0]           burst_len
);
    a_r1_reset_closed: assert property (@(posedge clk)
        !rst_n |=> (bank_open == '0) && !mode_valid && !illegal);

    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd1 && !illegal) |-> bank_open[cmd_bank]);

    a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd6) |-> !bank_open[cmd_bank]);

    a_r4_pall_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd7) |-> (bank_open == '0) && !illegal);

    a_r6_access_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_valid && cmd_code >= 4'd1 && cmd_code <= 4'd5) |-> illegal);

    a_r9_ap_full_page: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == 4'd3 || cmd_code == 4'd5) && burst_len[2]) |-> illegal);

    a_r10_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd8 && !illegal) |-> ($past(bank_open) == '0));
endmodule

bind sdram_cmd_tracker sdram_trk_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_code   (cmd_code),
    .cmd_bank   (cmd_bank),
    .illegal    (illegal),
    .bank_open  (bank_open),
    .mode_valid (mode_valid),
    .burst_len  (burst_len)
);

// File: tb/sdram_cmd_tracker_tb.sv
// Directed bench: each task drives one scenario and checks its own results.
// Inputs change on falling edges; outputs are sampled on the next falling edge.
module sdram_cmd_tracker_tb;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_MRS = 4'b0000;
    localparam logic [3:0] P_DES = 4'b1111;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [13:0] addr;
    logic [3:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic        illegal;
    logic [3:0]  bank_open;
    logic [47:0] bank_row;
    logic        mode_valid;
    logic [13:0] mode_word;
    logic [2:0]  burst_len;
    logic        burst_interleave;
    logic [2:0]  cas_latency;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cs_n             (cs_n),
        .ras_n            (ras_n),
        .cas_n            (cas_n),
        .we_n             (we_n),
        .addr             (addr),
        .cmd_code         (cmd_code),
        .cmd_bank         (cmd_bank),
        .illegal          (illegal),
        .bank_open        (bank_open),
        .bank_row         (bank_row),
        .mode_valid       (mode_valid),
        .mode_word        (mode_word),
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .cas_latency      (cas_latency)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one command for one clock and return at the next falling edge.
    task automatic issue(input logic [3:0] pins, input logic [13:0] a);
        {cs_n, ras_n, cas_n, we_n} = pins;
        addr = a;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R1 bank_open", bank_open, 0);
        chk("R1 mode_valid", mode_valid, 0);
        chk("R1 illegal", illegal, 0);
        chk("R1 cmd_code", cmd_code, 0);
    endtask

    task automatic t_before_mode();
        issue(P_ACT, 14'h0005);
        chk("R6 act before mode illegal", illegal, 1);
        chk("R2 act code", cmd_code, 1);
        chk("R6 no bank opened", bank_open, 0);
        issue(P_REF, 14'h0000);
        chk("R10 refresh idle legal", illegal, 0);
        chk("R2 refresh code", cmd_code, 8);
        issue(P_DES, 14'h0000);
        chk("R2 deselect code", cmd_code, 0);
    endtask

    task automatic t_mode_set();
        issue(P_MRS, 14'h003A);
        chk("R2 mode code", cmd_code, 9);
        chk("R5 mode_valid", mode_valid, 1);
        chk("R5 mode_word", mode_word, 14'h003A);
        chk("R5 burst_len", burst_len, 3'b010);
        chk("R5 interleave", burst_interleave, 1);
        chk("R5 cas_latency", cas_latency, 3);
    endtask

    task automatic t_open_close();
        issue(P_ACT, 14'h1ABC);
        chk("R3 bank1 open", bank_open, 4'b0010);
        chk("R3 bank1 row", bank_row[23:12], 12'hABC);
        chk("R3 cmd_bank", cmd_bank, 1);
        issue(P_ACT, 14'h2123);
        chk("R3 bank2 open", bank_open, 4'b0110);
        chk("R3 bank2 row", bank_row[35:24], 12'h123);
        issue(P_ACT, 14'h1555);
        chk("R7 act open bank illegal", illegal, 1);
        chk("R7 row unchanged", bank_row[23:12], 12'hABC);
        issue(P_RD, 14'h0010);
        chk("R7 read closed bank illegal", illegal, 1);
        chk("R7 state unchanged", bank_open, 4'b0110);
        issue(P_RD, 14'h1010);
        chk("R2 read code", cmd_code, 2);
        chk("R7 read open bank legal", illegal, 0);
        issue(P_WR, 14'h2000);
        chk("R2 write code", cmd_code, 4);
        chk("R7 write open bank legal", illegal, 0);
        issue(P_PRE, 14'h1000);
        chk("R2 precharge code", cmd_code, 6);
        chk("R4 only bank1 closed", bank_open, 4'b0100);
        issue(P_REF, 14'h0000);
        chk("R10 refresh with open bank illegal", illegal, 1);
        chk("R10 bank stays open", bank_open, 4'b0100);
        issue(P_PRE, 14'h0400);
        chk("R2 all-bank code", cmd_code, 7);
        chk("R4 all closed", bank_open, 0);
    endtask

    task automatic t_auto_read();
        issue(P_ACT, 14'h3055);
        issue(P_RD, 14'h3400);
        chk("R2 read auto code", cmd_code, 3);
        chk("R8 open after edge k", bank_open[3], 1);
        issue(P_RD, 14'h3000);
        chk("R8 read during pending illegal", illegal, 1);
        chk("R8 open after k+1", bank_open[3], 1);
        issue(P_DES, 14'h0000);
        chk("R8 open after k+2", bank_open[3], 1);
        issue(P_DES, 14'h0000);
        chk("R8 open after k+3", bank_open[3], 1);
        issue(P_DES, 14'h0000);
        chk("R8 closed after k+4", bank_open[3], 0);
    endtask

    task automatic t_auto_write();
        issue(P_MRS, 14'h0030);
        chk("R5 length one", burst_len, 0);
        issue(P_ACT, 14'h0007);
        issue(P_WR, 14'h0400);
        chk("R2 write auto code", cmd_code, 5);
        chk("R8 write auto legal", illegal, 0);
        chk("R8 open after edge k", bank_open[0], 1);
        issue(P_DES, 14'h0000);
        chk("R8 closed after k+1", bank_open[0], 0);
    endtask

    task automatic t_full_page();
        issue(P_MRS, 14'h0037);
        chk("R5 full page code", burst_len, 3'b111);
        issue(P_ACT, 14'h2001);
        issue(P_RD, 14'h2400);
        chk("R9 read auto full illegal", illegal, 1);
        issue(P_WR, 14'h2400);
        chk("R9 write auto full illegal", illegal, 1);
        repeat (9) issue(P_DES, 14'h0000);
        chk("R9 bank still open", bank_open[2], 1);
        issue(P_WR, 14'h2000);
        chk("R9 plain write legal", illegal, 0);
        issue(P_PRE, 14'h0400);
        chk("R4 all closed again", bank_open, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = P_DES;
        addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_before_mode();
        t_mode_set();
        t_open_close();
        t_auto_read();
        t_auto_write();
        t_full_page();
        finish_run();
    end
endmodule